// File: doc/BRIEF.md
# Counter-Driven Bidirectional Gray Code Converter

This block turns an 8-bit value into reflected Gray code, or treats the value as Gray code and decodes it back to plain binary. A direction input picks which of the two results is kept. The value being converted comes from one of two places. The first is an internal binary up-counter, which steps through successive codes on its own. The second is an external parallel data input.

Whichever result is chosen is captured in a parallel output register on the next rising clock edge. The output is therefore always a registered value that is one cycle old. The block is aimed at a 200 MHz clock, so both conversion paths and the selection logic must settle inside one 5 ns period.

In the counter-fed mode with Gray output, the block acts as a Gray sequence generator whose output changes by one bit per step. In the external mode it acts as a pipelined converter in either direction.

Top module: `gcv_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both `dout` and the internal counter are cleared to 0. The first value converted after reset is therefore counter value 0.
- R2: With `out_bin` = 0, `dout` after an edge equals the Gray encoding of the source value sampled at that edge. Bit 7 is copied unchanged, and each lower bit i is source bit i XOR source bit i+1.
- R3: With `out_bin` = 1, `dout` after an edge equals the binary decoding of the source value sampled at that edge, with the source read as Gray code. Bit 7 is copied unchanged, and each lower bit i is decoded bit i+1 XOR source bit i.
- R4: With `src_ext` = 0, the source is the internal counter. With `src_ext` = 1, the source is `din`, and the counter has no effect on `dout`.
- R5: At each edge out of reset, the counter increments by one when `cnt_en` = 1 and holds its value when `cnt_en` = 0.
- R6: The counter wraps from 255 to 0 and keeps counting.
- R7: With the counter as source, Gray output selected and `cnt_en` = 1, each new `dout` differs from the previous one in exactly one bit. This includes the step from 255 to 0.
- R8: For every 8-bit value x, decoding the Gray encoding of x returns x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter advance enable |
| src_ext | input | 1 | Source select: 0 selects the counter, 1 selects `din` |
| out_bin | input | 1 | Result select: 0 selects the Gray encoding, 1 selects the binary decoding |
| din | input | 8 | External value to convert |
| dout | output | 8 | Registered conversion result |

## Verification
The bench runs the counter through more than a full cycle of 256 values. Every output step is compared bit by bit with the previous one, so a counter that skips or stalls wrongly shows up as a multi-bit or zero-bit step. A broken wrap shows up as a wrong value after code 0x80. A decoder whose ripple chain is wired in the wrong direction or from the wrong neighbour fails the round trip on at least one of the 256 values. Random external data, mixed with both directions, catches a swapped source or direction select. Runs with the enable held low, and a reset in the middle of counting, catch a counter that drifts or is not cleared.

// File: rtl/gcv_pkg.sv
package gcv_pkg;
  typedef enum logic {SRC_COUNT = 1'b0, SRC_EXT = 1'b1} src_sel_e;
  typedef enum logic {SEL_GRAY = 1'b0, SEL_BIN = 1'b1} res_sel_e;
endpackage

// File: rtl/gcv_counter.sv
module gcv_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + ONE;  // natural wrap at 2**W
  end
endmodule

// File: rtl/gcv_b2g.sv
module gcv_b2g #(
  parameter int W = 8
) (
  input  logic [W-1:0] bin_in,
  output logic [W-1:0] gray_out
);
  function automatic logic [W-1:0] encode(input logic [W-1:0] b);
    logic [W-1:0] g;
    g[W-1] = b[W-1];
    for (int i = W - 2; i >= 0; i--) g[i] = b[i] ^ b[i+1];
    return g;
  endfunction

  assign gray_out = encode(bin_in);
endmodule

// File: rtl/gcv_g2b.sv
module gcv_g2b #(
  parameter int W = 8
) (
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  // ripple from the top bit downward
  function automatic logic [W-1:0] decode(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign bin_out = decode(gray_in);
endmodule

// File: rtl/gcv_unit.sv
module gcv_unit
  import gcv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         src_ext,
  input  logic         out_bin,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  src_sel_e     src_sel;
  res_sel_e     res_sel;
  logic [W-1:0] cnt_q;
  logic [W-1:0] src_val;
  logic [W-1:0] gray_w;
  logic [W-1:0] bin_w;
  logic [W-1:0] res_w;

  assign src_sel = src_sel_e'(src_ext);
  assign res_sel = res_sel_e'(out_bin);

  gcv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt_q)
  );

  assign src_val = (src_sel == SRC_EXT) ? din : cnt_q;

  gcv_b2g #(.W(W)) u_enc (.bin_in(src_val), .gray_out(gray_w));
  gcv_g2b #(.W(W)) u_dec (.gray_in(src_val), .bin_out(bin_w));

  assign res_w = (res_sel == SEL_BIN) ? bin_w : gray_w;

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= res_w;
  end
endmodule

// File: rtl/gcv_unit_chk.sv
module gcv_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         src_ext,
  input logic         out_bin,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] src_val,
  input logic [W-1:0] gray_w,
  input logic [W-1:0] bin_w
);
  logic seen_rst = 1'b0;
  logic armed    = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    armed <= !rst && seen_rst;
  end

  // prefix-parity form of the decode
  function automatic logic [W-1:0] pdec(input logic [W-1:0] g);
    logic [W-1:0] b;
    for (int i = 0; i < W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    seen_rst && $fell(rst) |-> (dout == '0 && cnt_q == '0));

  p_gray_path_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!out_bin) |-> pdec(dout) == $past(src_val));

  p_bin_path_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(out_bin) |-> (dout ^ (dout >> 1)) == $past(src_val));

  p_src_pick_r4: assert property (@(posedge clk) disable iff (rst)
    src_ext |-> src_val == din);

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cnt_en) |-> cnt_q == W'($past(cnt_q) + W'(1)));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!cnt_en) |-> $stable(cnt_q));

  p_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cnt_en) && !src_ext && $past(!src_ext)
      |-> $countones(gray_w ^ $past(gray_w)) == 1);

  p_round_trip_r8: assert property (@(posedge clk) disable iff (rst)
    (bin_w ^ (bin_w >> 1)) == src_val);
endmodule

bind gcv_unit gcv_unit_chk #(.W(W)) u_chk (.*);

// File: tb/test_gcv_unit.sv
`timescale 1ns/1ps
module test_gcv_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic         src_ext = 1'b0;
  logic         out_bin = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] m_cnt = '0;
  logic [W-1:0] prev_dout = '0;
  logic         prev_ok = 1'b0;
  logic         done = 1'b0;

  always #2.5 clk = ~clk;

  gcv_unit #(.W(W)) i_gcv_unit (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .src_ext(src_ext),
    .out_bin(out_bin), .din(din), .dout(dout)
  );

  function automatic logic [W-1:0] tb_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] tb_ungray(input logic [W-1:0] g);
    logic [W-1:0] b = '0;
    for (int s = 0; s < W; s++) b = b ^ (g >> s);
    return b;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock: expected value from inputs held across the edge
  task automatic step(input string tag);
    logic [W-1:0] s, e;
    s = src_ext ? din : m_cnt;
    e = out_bin ? tb_ungray(s) : tb_gray(s);
    @(posedge clk); #1;
    if (cnt_en) m_cnt = m_cnt + 1'b1;
    check(tag, dout, e);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", dout, '0);
    rst = 1'b0; cnt_en = 1'b1; src_ext = 1'b0; out_bin = 1'b0;
    m_cnt = '0;

    // counter through more than a full lap, Gray output
    for (int k = 0; k < 300; k++) begin
      step("R2 R5 R6 counter gray");
      if (prev_ok) begin
        n_run++;
        if ($countones(dout ^ prev_dout) != 1) begin
          n_fail++;
          $display("FAIL R7 one-bit step: got %02h expected one bit from %02h", dout, prev_dout);
        end
      end
      if (prev_dout == 8'h80 && prev_ok) check("R6 wrap to zero", dout, 8'h00);
      prev_dout = dout; prev_ok = 1'b1;
    end

    // hold
    cnt_en = 1'b0;
    for (int k = 0; k < 5; k++) step("R5 hold");
    check("R5 hold value", dout, tb_gray(m_cnt));

    // counter in decode direction
    out_bin = 1'b1; cnt_en = 1'b1;
    for (int k = 0; k < 20; k++) step("R3 counter decode");

    // external source, random directions; counter ignored
    src_ext = 1'b1;
    for (int k = 0; k < 200; k++) begin
      din = W'($urandom);
      out_bin = $urandom_range(0, 1);
      cnt_en = $urandom_range(0, 1);
      step("R4 external source");
    end
    din = 8'hFF; out_bin = 1'b0; step("R2 all ones");
    din = 8'hFF; out_bin = 1'b1; step("R3 all ones");
    din = 8'h80; out_bin = 1'b1; step("R3 top bit only");

    // round trip over every value
    cnt_en = 1'b0;
    for (int x = 0; x < 256; x++) begin
      logic [W-1:0] g;
      din = W'(x); out_bin = 1'b0; step("R8 encode");
      g = dout;
      din = g; out_bin = 1'b1; step("R8 decode");
      check("R8 round trip", dout, W'(x));
    end

    // reset during counting
    src_ext = 1'b0; out_bin = 1'b1; cnt_en = 1'b1;
    for (int k = 0; k < 37; k++) step("R5 count");
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset", dout, '0);
    rst = 1'b0; m_cnt = '0; out_bin = 1'b0;
    for (int k = 0; k < 4; k++) step("R1 restart from zero");
    check("R1 restart value", dout, tb_gray(8'd3));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule